// File: doc/BRIEF.md
# Hot-Swap Bus Connection Sequencer

This block is the control sequencer of a two-sided I2C/SMBus hot-swap buffer. One side faces the plug-in card and the other faces the backplane. It watches a pair of supply comparator flags for each side and synchronized samples of the four bus lines. It decides when the two bus segments may safely be joined. The analog parts (pass devices, precharge resistors, rise accelerators and comparators) sit outside the block and see only its enable outputs.

After reset the sequencer holds in lockout with every enable off. Each side's supply is judged with hysteresis: a rising-threshold flag marks the side valid and a falling-threshold flag marks it invalid. Once both sides are valid, in either order, the sequencer biases the lines through the precharge enable for a fixed initialization period. It then arms an idle detector. The two segments are joined once the bus is proven quiet, in one of two ways:
- all four lines have been high for a programmable number of cycles, or
- all four lines are high and a stop condition appears on the card side.

Losing either supply sends the block back to lockout from any state.

Top module: `hotswap_link_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, connect, precharge, accel and ready are all low.
- R2: The block leaves lockout only when both supply sides are valid, and the order in which they become valid does not matter. Precharge rises two clock edges after the second rising-threshold flag is sampled.
- R3: Each side's validity is a latch. The rising-threshold flag sets it and the falling-threshold flag clears it, and the falling flag wins when both are high. A cleared side stays invalid until its rising flag is seen again.
- R4: From any state, a falling-threshold flag on either side forces connect, precharge, accel and ready low two clock edges after it is sampled.
- R5: Initialization lasts INIT_CYCLES clock cycles. During it precharge is high, connect is low, and a stop condition is ignored.
- R6: Once armed, the sides connect on the clock edge that follows IDLE_CYCLES consecutive synchronized samples with all four lines high.
- R7: A low synchronized sample on any of the four lines restarts the idle count.
- R8: While armed, a stop condition connects the sides on the next clock edge, provided all four synchronized lines are high. A stop condition is defined as follows: on two consecutive synchronized samples, the card-side clock is high in both, and the card-side data goes from low to high.
- R9: Precharge falls in the same cycle that connect rises. Ready equals connect at all times.
- R10: The accel output equals connect AND accel_allow_i. Driving accel_allow_i low disables acceleration without changing connect.
- R11: Every bus-line input passes two synchronizer flops before any detection, so a line change first takes effect in the cycle after the second clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| card_rise_ok_i | input | 1 | Card-side supply above rising threshold |
| card_fall_bad_i | input | 1 | Card-side supply below falling threshold |
| bp_rise_ok_i | input | 1 | Backplane-side supply above rising threshold |
| bp_fall_bad_i | input | 1 | Backplane-side supply below falling threshold |
| card_sda_i | input | 1 | Card-side data line sample (asynchronous) |
| card_scl_i | input | 1 | Card-side clock line sample (asynchronous) |
| bp_sda_i | input | 1 | Backplane-side data line sample (asynchronous) |
| bp_scl_i | input | 1 | Backplane-side clock line sample (asynchronous) |
| accel_allow_i | input | 1 | Low disables the rise accelerators |
| connect_o | output | 1 | Join the two bus segments |
| precharge_o | output | 1 | Enable line precharge bias |
| accel_o | output | 1 | Enable rise-time accelerators |
| ready_o | output | 1 | Segments are connected |

## Verification
The bench builds the block with INIT_CYCLES = 12 and IDLE_CYCLES = 20. At these values the full sequence, from lockout through initialization to the idle timeout, takes only a few dozen cycles, so every transition edge can be checked at its exact cycle. The short initialization window still leaves room to place a complete stop condition inside it. The short idle window lets the bench interrupt the count and watch it restart. Supply loss is exercised from initialization, from the armed state and from the connected state, with both supply orders.

// File: rtl/hslc_pkg.sv
package hslc_pkg;
  typedef enum logic [1:0] {
    ST_LOCK = 2'd0,
    ST_INIT = 2'd1,
    ST_ARM  = 2'd2,
    ST_LINK = 2'd3
  } hslc_state_e;

  localparam int unsigned LINE_COUNT = 4;
  localparam int unsigned LN_CARD_SDA = 0;
  localparam int unsigned LN_CARD_SCL = 1;
  localparam int unsigned LN_BP_SDA   = 2;
  localparam int unsigned LN_BP_SCL   = 3;
  localparam int unsigned SIDE_COUNT  = 2;
endpackage

// File: rtl/hslc_sync.sv
module hslc_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  // Lines idle high: reset to ones so no false edge after reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q[0] <= '1;
    else        stg_q[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= '1;
      else        stg_q[s] <= stg_q[s-1];
    end
  end

  assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/hslc_supply.sv
module hslc_supply #(
  parameter int unsigned SIDES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SIDES-1:0] rise_ok_i,
  input  logic [SIDES-1:0] fall_bad_i,
  output logic             all_ok_o
);
  logic [SIDES-1:0] valid_q;

  for (genvar i = 0; i < SIDES; i++) begin : g_side
    logic valid_d;
    always_comb begin
      valid_d = valid_q[i];
      if (fall_bad_i[i])     valid_d = 1'b0;
      else if (rise_ok_i[i]) valid_d = 1'b1;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid_q[i] <= 1'b0;
      else        valid_q[i] <= valid_d;
    end
  end

  assign all_ok_o = &valid_q;
endmodule

// File: rtl/hslc_idle.sv
module hslc_idle
  import hslc_pkg::*;
#(
  parameter int unsigned IDLE_CYCLES = 1000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  arm_i,
  input  logic [LINE_COUNT-1:0] lines_i,
  output logic                  idle_done_o,
  output logic                  stop_seen_o
);
  localparam int unsigned CW = $clog2(IDLE_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(IDLE_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          sda_prev_q, scl_prev_q;
  logic          all_high, run;

  assign all_high = &lines_i;
  assign run      = arm_i & all_high;

  assign idle_done_o = run & (cnt_q == CNT_LAST);
  assign stop_seen_o = arm_i & all_high & ~sda_prev_q & scl_prev_q;

  always_comb begin
    cnt_en = 1'b1;
    cnt_d  = '0;
    if (run) begin
      cnt_en = ~idle_done_o;
      cnt_d  = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_prev_q <= 1'b1;
      scl_prev_q <= 1'b1;
    end else begin
      sda_prev_q <= lines_i[LN_CARD_SDA];
      scl_prev_q <= lines_i[LN_CARD_SCL];
    end
  end
endmodule

// File: rtl/hotswap_link_ctrl.sv
module hotswap_link_ctrl
  import hslc_pkg::*;
#(
  parameter int unsigned INIT_CYCLES = 64,
  parameter int unsigned IDLE_CYCLES = 1000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic card_rise_ok_i,
  input  logic card_fall_bad_i,
  input  logic bp_rise_ok_i,
  input  logic bp_fall_bad_i,
  input  logic card_sda_i,
  input  logic card_scl_i,
  input  logic bp_sda_i,
  input  logic bp_scl_i,
  input  logic accel_allow_i,
  output logic connect_o,
  output logic precharge_o,
  output logic accel_o,
  output logic ready_o
);
  localparam int unsigned IW = $clog2(INIT_CYCLES + 1);
  localparam logic [IW-1:0] INIT_LAST = IW'(INIT_CYCLES - 1);

  hslc_state_e state_q, state_d;
  logic [LINE_COUNT-1:0] lines_raw, lines_s;
  logic sup_ok, idle_done, stop_seen, init_done;
  logic [IW-1:0] init_cnt_q, init_cnt_d;

  assign lines_raw[LN_CARD_SDA] = card_sda_i;
  assign lines_raw[LN_CARD_SCL] = card_scl_i;
  assign lines_raw[LN_BP_SDA]   = bp_sda_i;
  assign lines_raw[LN_BP_SCL]   = bp_scl_i;

  hslc_sync #(.WIDTH(LINE_COUNT), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(lines_raw), .sync_o(lines_s)
  );

  hslc_supply #(.SIDES(SIDE_COUNT)) u_supply (
    .clk(clk), .rst_n(rst_n),
    .rise_ok_i({bp_rise_ok_i, card_rise_ok_i}),
    .fall_bad_i({bp_fall_bad_i, card_fall_bad_i}),
    .all_ok_o(sup_ok)
  );

  hslc_idle #(.IDLE_CYCLES(IDLE_CYCLES)) u_idle (
    .clk(clk), .rst_n(rst_n), .arm_i(state_q == ST_ARM),
    .lines_i(lines_s), .idle_done_o(idle_done), .stop_seen_o(stop_seen)
  );

  assign init_done  = (state_q == ST_INIT) && (init_cnt_q == INIT_LAST);
  assign init_cnt_d = (state_q == ST_INIT) ? init_cnt_q + IW'(1) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) init_cnt_q <= '0;
    else        init_cnt_q <= init_cnt_d;
  end

  always_comb begin
    state_d = state_q;
    if (!sup_ok) begin
      state_d = ST_LOCK;
    end else begin
      unique case (state_q)
        ST_LOCK: state_d = ST_INIT;
        ST_INIT: if (init_done) state_d = ST_ARM;
        ST_ARM:  if (idle_done || stop_seen) state_d = ST_LINK;
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_LOCK;
    else        state_q <= state_d;
  end

  assign connect_o   = (state_q == ST_LINK);
  assign precharge_o = (state_q == ST_INIT) || (state_q == ST_ARM);
  assign accel_o     = connect_o & accel_allow_i;
  assign ready_o     = connect_o;
endmodule

// File: rtl/hslc_checker.sv
module hslc_checker (
  input logic clk,
  input logic rst_n,
  input logic sup_ok,
  input logic connect_o,
  input logic precharge_o,
  input logic accel_o,
  input logic ready_o
);
  // R4
  supply_loss_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_ok |=> (!connect_o && !precharge_o && !accel_o && !ready_o));

  // R9
  ready_tracks_connect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o == connect_o);

  // R9
  no_precharge_when_linked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    connect_o |-> !precharge_o);

  // R10
  accel_needs_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accel_o |-> connect_o);

  // R5
  link_from_precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(connect_o) |-> $past(precharge_o));

  // R2
  precharge_needs_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(precharge_o) |-> $past(sup_ok));
endmodule

bind hotswap_link_ctrl hslc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sup_ok(sup_ok), .connect_o(connect_o),
  .precharge_o(precharge_o), .accel_o(accel_o), .ready_o(ready_o)
);

// File: tb/hotswap_link_ctrl_test.sv
module hotswap_link_ctrl_test;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned INIT_N = 12;
  localparam int unsigned IDLE_N = 20;

  logic clk, rst_n;
  logic card_rise, card_fall, bp_rise, bp_fall;
  logic card_sda, card_scl, bp_sda, bp_scl, accel_allow;
  logic connect, precharge, accel, ready;
  int checks, errors, e;

  hotswap_link_ctrl #(.INIT_CYCLES(INIT_N), .IDLE_CYCLES(IDLE_N)) uut (
    .clk(clk), .rst_n(rst_n),
    .card_rise_ok_i(card_rise), .card_fall_bad_i(card_fall),
    .bp_rise_ok_i(bp_rise), .bp_fall_bad_i(bp_fall),
    .card_sda_i(card_sda), .card_scl_i(card_scl),
    .bp_sda_i(bp_sda), .bp_scl_i(bp_scl), .accel_allow_i(accel_allow),
    .connect_o(connect), .precharge_o(precharge), .accel_o(accel), .ready_o(ready)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Outputs packed {connect, precharge, accel, ready}.
  function automatic logic [31:0] outs();
    return {28'd0, connect, precharge, accel, ready};
  endfunction

  task automatic step();
    @(negedge clk);
    e++;
  endtask

  task automatic step_to(input int target);
    while (e < target) step();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    checks = 0; errors = 0; e = 0;
    rst_n = 1'b0;
    card_rise = 0; card_fall = 0; bp_rise = 0; bp_fall = 0;
    card_sda = 1; card_scl = 1; bp_sda = 1; bp_scl = 1; accel_allow = 1;
    repeat (3) @(negedge clk);
    check("R1 in reset", outs(), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", outs(), 32'h0);

    // Scenario A: card supply first, stop during init, idle timeout.
    card_rise = 1;
    repeat (5) @(negedge clk);
    check("R2 one side only", outs(), 32'h0);
    card_sda = 0;
    bp_rise = 1; e = 0;
    step();
    check("R2 one edge after second rise", outs(), 32'h0);
    step();
    check("R2 precharge on", outs(), 32'b0100);
    step_to(3);
    card_sda = 1; // stop condition lands inside initialization
    step_to(1 + INIT_N);
    check("R5 still initializing", outs(), 32'b0100);
    step_to(1 + INIT_N + IDLE_N);
    check("R5 stop in init ignored", outs(), 32'b0100);
    step();
    check("R6 idle connect", outs(), 32'b1011);
    accel_allow = 0; #1;
    check("R10 accel disabled", outs(), 32'b1001);
    accel_allow = 1; #1;
    check("R10 accel enabled", outs(), 32'b1011);

    // Supply loss from the connected state.
    card_fall = 1; card_rise = 0; e = 0;
    step();
    check("R4 one edge after fall", outs(), 32'b1011);
    step();
    check("R4 lockout from link", outs(), 32'h0);
    card_fall = 0;
    repeat (10) step();
    check("R3 stays invalid", outs(), 32'h0);

    // Scenario B: backplane already valid; fall beats rise.
    card_rise = 1; card_fall = 1;
    bp_sda = 0; card_sda = 0;
    repeat (5) step();
    check("R3 fall wins", outs(), 32'h0);
    card_fall = 0; e = 0;
    step_to(2);
    check("R2 other order", outs(), 32'b0100);
    step_to(2 + INIT_N + 5);
    check("R7 low lines keep armed", outs(), 32'b0100);
    card_sda = 1;
    repeat (6) step();
    check("R8 stop needs all high", outs(), 32'b0100);
    bp_sda = 1;
    repeat (IDLE_N - 2) step();
    bp_scl = 0;
    step();
    bp_scl = 1; e = 0;
    step_to(4);
    check("R7 count restarted", outs(), 32'b0100);
    step_to(1 + IDLE_N);
    check("R7 one short of idle", outs(), 32'b0100);
    step();
    check("R6 idle connect after restart", outs(), 32'b1011);

    bp_fall = 1; bp_rise = 0;
    repeat (2) step();
    check("R4 backplane loss", outs(), 32'h0);

    // Scenario C: loss during init, then stop path.
    bp_fall = 0; bp_rise = 1; card_sda = 0;
    repeat (2) step();
    check("R2 init again", outs(), 32'b0100);
    card_fall = 1; card_rise = 0;
    repeat (2) step();
    check("R4 lockout from init", outs(), 32'h0);
    card_fall = 0; card_rise = 1; e = 0;
    step_to(2 + INIT_N + 3);
    check("R5 armed waiting", outs(), 32'b0100);
    card_sda = 1;
    repeat (2) step();
    check("R11 two flop latency", outs(), 32'b0100);
    step();
    check("R8 stop connect", outs(), 32'b1011);
    check("R9 precharge off ready on", {30'd0, precharge, ready}, 32'b01);

    finish_run();
  end
endmodule